// File: doc/BRIEF.md
# Reset Configuration Word Fetcher

This block runs right after hard reset as the configuration master of a board-level reset scheme. It reads a table of bytes from the boot memory and packs them into 32-bit configuration words. The first word is its own. The next seven are held for up to seven slave devices. It talks to the boot device through a plain read request/acknowledge interface. It takes one byte per read, always from the most significant lane of the returned data bus. The reads fall on a fixed stride of eight addresses, so the width of the boot port makes no difference.

The block outputs the master word as soon as its bytes arrive. It also outputs two values derived from one bit of the master word: the exception base address and the reset vector, which sits at offset 0x100 above that base. An index input selects any stored word for a reader, and a done flag reports that the whole table has been fetched. Once the flag is set, every word stays frozen until the next reset.

Top module: `cfg_fetch_top`

## Requirements
- R1: While rstN is low (sampled on the rising clock edge), rdReq, cfgDone and every stored word are 0. The first read request appears one clock after reset is released.
- R2: Exactly 32 reads complete per reset. The first address is 0 and each completed read raises rdAddr by 8.
- R3: Each completed read captures only rdData[DATA_W-1:DATA_W-8], the most significant byte lane (bits 63:56 at the default width). The other lanes have no effect on any output.
- R4: Read number n (counting from 0) belongs to word n/4. Word 0 is the master word and words 1 to 7 belong to slaves 1 to 7.
- R5: Within a word, the first byte read lands in bits 31:24, the second in bits 23:16, the third in bits 15:8 and the fourth in bits 7:0.
- R6: A read completes only on a clock edge where rdReq and rdAck are both high. Without rdAck, rdReq stays high, rdAddr holds and nothing is captured.
- R7: vecBase is 0x00000000 when masterWord bit PREFIX_BIT (default 22) is 0, and 0xFFF00000 when it is 1. resetVector equals vecBase + 0x100 at all times.
- R8: cfgDone rises on the clock after the 32nd byte is captured and stays high until reset. From then on, rdReq is low, rdAck is ignored and all words hold their values.
- R9: slaveWord shows stored word number slaveIdx as a combinational read: 0 selects the master word and 1 to 7 select the slave words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | output | 1 | Read request to the boot device |
| rdAddr | output | ADDR_W (16) | Byte address of the current read |
| rdAck | input | 1 | Read acknowledge; data is valid in the same cycle |
| rdData | input | DATA_W (64) | Boot data bus; only the top byte lane is used |
| slaveIdx | input | 3 | Selects the stored word shown on slaveWord |
| slaveWord | output | 32 | Selected stored word |
| masterWord | output | 32 | Master configuration word (word 0) |
| vecBase | output | 32 | Exception base chosen by the prefix bit |
| resetVector | output | 32 | Reset vector address, vecBase + 0x100 |
| cfgDone | output | 1 | Whole table fetched; words frozen |

## Verification
The fetch is run against four different byte tables and four acknowledge patterns: acknowledge in every cycle, acknowledge every third cycle, long stalls, and short bursts. Back-to-back acknowledges expose address stepping and counting faults. The stalled patterns show whether a byte is taken without a handshake or whether the address moves while waiting. The tables vary the prefix bit between 0 and 1, which checks both base selections. The upper lanes carry a changing pattern that differs from the top byte, so a wrong lane choice appears as a word mismatch. One run resets in the middle of a fetch and then restarts, which shows that all state clears and the full table is fetched again. Acknowledges keep arriving after the flag is set, which shows that the frozen state really holds.

// File: rtl/cfg_fetch_pkg.sv
package cfg_fetch_pkg;

  localparam int unsigned CFG_WORD_W     = 32;
  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned BYTES_PER_WORD = CFG_WORD_W / BYTE_W;
  localparam int unsigned WORD_CNT       = 8;
  localparam int unsigned WIDX_W         = $clog2(WORD_CNT);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } fetchState_t;

  // Strobes from the control path to the word assembly datapath
  typedef struct packed {
    logic              capture;
    logic [WIDX_W-1:0] wordIdx;
  } ctlStrobe_t;

endpackage

// File: rtl/cfg_fetch_ctrl.sv
module cfg_fetch_ctrl
  import cfg_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned STRIDE      = 8,
  parameter int unsigned TOTAL_READS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdAck,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fetchDone,
  output ctlStrobe_t        strobe
);

  localparam int unsigned CNT_W     = $clog2(TOTAL_READS);
  localparam int unsigned STRIDE_SH = $clog2(STRIDE);
  localparam int unsigned BYTE_SH   = $clog2(BYTES_PER_WORD);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TOTAL_READS - 1);

  fetchState_t      state;
  logic [CNT_W-1:0] readCnt;
  logic             handshake;
  logic             lastRead;
  logic [CNT_W-1:0] wordCnt;

  assign handshake = (state == ST_FETCH) && rdAck;
  assign lastRead  = (readCnt == LAST_CNT);
  assign wordCnt   = readCnt >> BYTE_SH;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      readCnt <= '0;
    end else begin
      case (state)
        ST_IDLE:  state <= ST_FETCH;
        ST_FETCH: begin
          if (handshake) begin
            readCnt <= readCnt + 1'b1;
            if (lastRead) state <= ST_DONE;
          end
        end
        ST_DONE:  state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign rdReq          = (state == ST_FETCH);
  assign rdAddr         = ADDR_W'(readCnt) << STRIDE_SH;
  assign fetchDone      = (state == ST_DONE);
  assign strobe.capture = handshake;
  assign strobe.wordIdx = WIDX_W'(wordCnt);

  // R2: each completed read moves the address up by one stride
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAck && !lastRead) |=> (rdAddr == $past(rdAddr) + ADDR_W'(STRIDE)));

  // R6: without acknowledge the request and address hold
  a_r6_wait_ack: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr)));

  // R8: done is sticky and the request is withdrawn
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |=> (fetchDone && !rdReq));

  // R2: the final handshake ends the fetch
  a_r2_last_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAck && lastRead) |=> fetchDone);

endmodule

// File: rtl/cfg_fetch_datapath.sv
module cfg_fetch_datapath
  import cfg_fetch_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [BYTE_W-1:0]     laneByte,
  input  logic [WIDX_W-1:0]     slaveIdx,
  output logic [CFG_WORD_W-1:0] masterWord,
  output logic [CFG_WORD_W-1:0] slaveWord
);

  logic [CFG_WORD_W-1:0] words [WORD_CNT];

  // Shifting left by one byte per capture puts the first byte in the MSB
  for (genvar g = 0; g < WORD_CNT; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        words[g] <= '0;
      end else if (strobe.capture && (strobe.wordIdx == WIDX_W'(g))) begin
        words[g] <= {words[g][CFG_WORD_W-BYTE_W-1:0], laneByte};
      end
    end
  end

  assign masterWord = words[0];
  assign slaveWord  = words[slaveIdx];

  // R5: a capture leaves the new byte in the low byte of its word
  a_r5_byte_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (words[$past(strobe.wordIdx)][BYTE_W-1:0] == $past(laneByte)));

  // R4: with no capture pending, the master word holds
  a_r4_master_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capture && strobe.wordIdx == '0) |=> $stable(masterWord));

endmodule

// File: rtl/cfg_fetch_top.sv
module cfg_fetch_top
  import cfg_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned STRIDE     = 8,
  parameter int unsigned PREFIX_BIT = 22
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  input  logic [2:0]        slaveIdx,
  output logic [31:0]       slaveWord,
  output logic [31:0]       masterWord,
  output logic [31:0]       vecBase,
  output logic [31:0]       resetVector,
  output logic              cfgDone
);

  localparam int unsigned TOTAL_READS = WORD_CNT * BYTES_PER_WORD;
  localparam logic [31:0] HIGH_BASE   = 32'hFFF0_0000;
  localparam logic [31:0] VEC_OFFSET  = 32'h0000_0100;

  ctlStrobe_t        strobe;
  logic [BYTE_W-1:0] laneByte;
  logic              unusedLanes;

  assign laneByte    = rdData[DATA_W-1 -: BYTE_W];
  assign unusedLanes = ^rdData[DATA_W-BYTE_W-1:0];

  cfg_fetch_ctrl #(
    .ADDR_W      (ADDR_W),
    .STRIDE      (STRIDE),
    .TOTAL_READS (TOTAL_READS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdAck     (rdAck),
    .rdReq     (rdReq),
    .rdAddr    (rdAddr),
    .fetchDone (cfgDone),
    .strobe    (strobe)
  );

  cfg_fetch_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .laneByte   (laneByte),
    .slaveIdx   (slaveIdx),
    .masterWord (masterWord),
    .slaveWord  (slaveWord)
  );

  assign vecBase     = masterWord[PREFIX_BIT] ? HIGH_BASE : 32'h0;
  assign resetVector = vecBase + VEC_OFFSET;

  // R7: the base takes only the two legal values
  a_r7_base_legal: assert property (@(posedge clk) disable iff (!rstN)
    (vecBase == 32'h0) || (vecBase == HIGH_BASE));

  // R8: once done, the master word is frozen
  a_r8_words_frozen: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> $stable(masterWord));

endmodule

// File: tb/cfg_fetch_top_bench.sv
module cfg_fetch_top_bench;

  localparam int PB = 22;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdReq;
  logic [15:0] rdAddr;
  logic        rdAck = 1'b0;
  logic [63:0] rdData = '0;
  logic [2:0]  slaveIdx = '0;
  logic [31:0] slaveWord, masterWord, vecBase, resetVector;
  logic        cfgDone;

  always #4 clk = ~clk;

  cfg_fetch_top u_cfg_fetch_top (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck),
    .rdData(rdData), .slaveIdx(slaveIdx), .slaveWord(slaveWord),
    .masterWord(masterWord), .vecBase(vecBase), .resetVector(resetVector),
    .cfgDone(cfgDone)
  );

  // Behavioural boot memory and reference model
  logic [7:0]  bootMem [256];
  logic [31:0] mW [8];
  int  mCnt = 0;
  bit  mStarted = 0;
  bit  mDone = 0;
  int  hsCount = 0;
  int  cyc = 0;
  int  ackMode = 0;
  int  vectors = 0;
  int  miscompares = 0;

  always @(posedge clk) begin
    cyc++;
    if (rstN && rdReq && rdAck) hsCount++;
    if (!rstN) begin
      mStarted = 0; mDone = 0; mCnt = 0;
      for (int i = 0; i < 8; i++) mW[i] = '0;
    end else if (!mStarted) begin
      mStarted = 1;
    end else if (!mDone && rdAck) begin
      mW[mCnt / 4] = {mW[mCnt / 4][23:0], bootMem[mCnt * 8]};
      if (mCnt == 31) mDone = 1;
      mCnt++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic bit ackFor(int c);
    case (ackMode)
      0: return 1'b1;
      1: return (c % 3) == 0;
      2: return (c % 11) >= 8;
      default: return (c % 5) < 2;
    endcase
  endfunction

  // Compare away from the active edge, then drive the next inputs
  always @(negedge clk) begin
    logic [31:0] expBase;
    vectors++;
    expBase = mW[0][PB] ? 32'hFFF0_0000 : 32'h0;
    chk("R1/R6/R8 rdReq", {31'b0, rdReq}, {31'b0, mStarted && !mDone});
    chk("R8 cfgDone", {31'b0, cfgDone}, {31'b0, mDone});
    if (mStarted && !mDone) chk("R2 rdAddr", {16'b0, rdAddr}, 32'(mCnt * 8));
    chk("R3/R4/R5 masterWord", masterWord, mW[0]);
    chk("R9 slaveWord", slaveWord, mW[slaveIdx]);
    chk("R7 vecBase", vecBase, expBase);
    chk("R7 resetVector", resetVector, expBase + 32'h100);
    rdAck    <= ackFor(cyc);
    slaveIdx <= 3'(cyc % 8);
    rdData   <= {bootMem[rdAddr[7:0]],
                 56'h5A_C3_96_0F_E1_72_3B ^ {24'b0, 32'(cyc * 977)} ^ {8{~bootMem[rdAddr[7:0]]}}[55:0]};
  end

  task automatic fillTable(int seed, bit prefix);
    for (int a = 0; a < 256; a++) bootMem[a] = 8'((a * 37 + seed * 11) ^ (seed << 3));
    // prefix bit 22 is bit 6 of the master's second byte (read 1, address 8)
    bootMem[8][6] = prefix;
  endtask

  task automatic resetFor(int n);
    @(negedge clk); rstN = 1'b0;
    repeat (n) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runFetch(int seed, int mode, bit prefix, int abortAt);
    ackMode = mode;
    fillTable(seed, prefix);
    resetFor(3);
    hsCount = 0;
    if (abortAt > 0) begin
      repeat (abortAt) @(negedge clk);
      resetFor(2);               // R1: mid-fetch reset clears everything
      hsCount = 0;
    end
    while (!mDone && cyc < 150000) @(negedge clk);
    repeat (24) @(negedge clk);  // R8: acks keep arriving after done
    vectors++;
    chk("R2 handshake count", 32'(hsCount), 32'd32);
    vectors++;
    chk("R7 prefix selects base", {31'b0, vecBase == 32'hFFF0_0000}, {31'b0, prefix});
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mW[i] = '0;
    for (int a = 0; a < 256; a++) bootMem[a] = '0;
    runFetch(1, 0, 1'b0, 0);
    runFetch(2, 1, 1'b1, 0);
    runFetch(3, 2, 1'b1, 40);
    runFetch(4, 3, 1'b0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    miscompares++;
    $display("FAIL watchdog: actual cycle %0d expected run finished", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule